// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers 64 level-sensitive request lines, qualifies each one against its own enable bit and a 4-bit priority, and hands the processor a single vector word. The word names the winning source and carries the priority that won. One request output follows that word. It is high whenever the word is valid.

Software reaches the block through one 32-bit word-addressed write/read port. An enable can be set or cleared by writing a source number. A bulk mask can set or clear the enables of one 32-source half. Priority fields are packed eight to a word. A threshold register hides every source at or below a chosen priority. A handler can read the threshold, raise it while it runs and write the saved value back afterwards. The vector word and the request output are registered. A read therefore returns a value that was settled on the previous clock edge.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset all enables are 0, every priority field is 0, the threshold register reads 0x1F, the vector register (address 0x00) reads 0xFFFFFFFF, and `irq_o` is low.
- R2: Writing a value v below 64 to address 0x02 sets the enable of source v and leaves every other enable unchanged. A value of 64 or more changes nothing.
- R3: Writing a value v below 64 to address 0x03 clears the enable of source v and leaves every other enable unchanged.
- R4: Writing a mask to address 0x04 (sources 0–31) or 0x05 (sources 32–63) sets the enables where the mask has a 1 and leaves the others unchanged. Reading these addresses returns the current enables, with bit k standing for source k of that half.
- R5: Writing a mask to address 0x06 (sources 0–31) or 0x07 (sources 32–63) clears the enables where the mask has a 1 and leaves the others unchanged.
- R6: The priority of source n is held at word address 0x1F − n/8, in bits (n mod 8)·4+3 down to (n mod 8)·4. These words read back as written.
- R7: A source qualifies when its input is high, it is enabled, and it passes the threshold. The vector word gives the qualifying source with the highest priority: its number in bits 31:16 and its priority in bits 15:0.
- R8: When qualifying sources share the highest priority, the one with the highest source number wins.
- R9: The threshold register at address 0x01 holds 5 bits and reads back as written. With bit 4 clear, a source qualifies only if its priority is strictly greater than bits 3:0. With bit 4 set, the threshold hides nothing.
- R10: When no source qualifies, the vector word reads 0xFFFFFFFF and `irq_o` is low. Otherwise `irq_o` is high.
- R11: The vector word and `irq_o` reflect the inputs and registers as they stood at the previous rising clock edge. A source whose level drops stops being presented one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 64 | Level request per source |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets four kinds of error.

- **Tie-breaking.** Equal-priority contenders are placed at both ends of the source range, so an arbiter that favours the lower number returns the wrong source.
- **Field placement.** Sources in the first and last priority words are programmed. A design whose priority words ascend in address, or that sits fields at the wrong nibble, then shows the wrong priority in the vector word, or shows none.
- **Threshold boundary.** One check puts a source's priority exactly equal to the threshold, which a comparison using "at or above" would wrongly let through. The threshold is then restored, to confirm the value reads back and the winner reappears.
- **Targeted enable writes.** Number-based and bulk enable writes are followed by read-back of the neighbouring enables, so a write that disturbs other bits is caught. An out-of-range number that altered a bit is caught the same way.

Finally, the bench samples the output on the exact edge after an input rises and after it falls. An extra or a missing pipeline stage therefore shows up as a mismatch.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Word addresses of the register port
  localparam int unsigned A_VECTOR   = 'h00;
  localparam int unsigned A_THRESH   = 'h01;
  localparam int unsigned A_SET_NUM  = 'h02;
  localparam int unsigned A_CLR_NUM  = 'h03;
  localparam int unsigned A_SET_BULK = 'h04;  // one word per 32 sources
  localparam int unsigned A_CLR_BULK = 'h06;  // one word per 32 sources
  localparam int unsigned A_PRIO_TOP = 'h1F;  // source 0..7; higher sources descend

endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM_SRC-1:0]         en_o,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
  output logic [PRIO_W:0]            thresh_o
);

  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned EN_WORDS  = NUM_SRC / DATA_W;
  localparam int unsigned PER_PWORD = DATA_W / PRIO_W;
  localparam int unsigned PR_WORDS  = NUM_SRC / PER_PWORD;

  logic [NUM_SRC-1:0]        en_q, en_d;
  logic [NUM_SRC*PRIO_W-1:0] prio_q, prio_d;
  logic [PRIO_W:0]           thr_q, thr_d;
  logic                      num_ok;

  assign num_ok = (wdata_i < DATA_W'(NUM_SRC));

  // Next-state for enables
  always_comb begin
    en_d = en_q;
    if (addr_i == ADDR_W'(A_SET_NUM) && num_ok)
      en_d[wdata_i[IDX_W-1:0]] = 1'b1;
    if (addr_i == ADDR_W'(A_CLR_NUM) && num_ok)
      en_d[wdata_i[IDX_W-1:0]] = 1'b0;
    for (int w = 0; w < EN_WORDS; w++) begin
      if (addr_i == ADDR_W'(A_SET_BULK + w))
        en_d[w*DATA_W +: DATA_W] = en_q[w*DATA_W +: DATA_W] | wdata_i;
      if (addr_i == ADDR_W'(A_CLR_BULK + w))
        en_d[w*DATA_W +: DATA_W] = en_q[w*DATA_W +: DATA_W] & ~wdata_i;
    end
  end

  // Next-state for priority words (descending addresses)
  always_comb begin
    prio_d = prio_q;
    for (int p = 0; p < PR_WORDS; p++) begin
      if (addr_i == ADDR_W'(A_PRIO_TOP - p))
        prio_d[p*DATA_W +: DATA_W] = wdata_i;
    end
  end

  // Next-state for threshold
  always_comb begin
    thr_d = thr_q;
    if (addr_i == ADDR_W'(A_THRESH))
      thr_d = wdata_i[PRIO_W:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
      thr_q  <= '1;
    end else if (wr_en_i) begin
      en_q   <= en_d;
      prio_q <= prio_d;
      thr_q  <= thr_d;
    end
  end

  assign en_o     = en_q;
  assign prio_o   = prio_q;
  assign thresh_o = thr_q;

endmodule

// File: rtl/intc_qual.sv
module intc_qual #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]        irq_src_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W:0]           thresh_i,
  output logic [NUM_SRC-1:0]        qual_o
);

  logic             no_limit;
  logic [PRIO_W-1:0] limit;

  assign no_limit = thresh_i[PRIO_W];
  assign limit    = thresh_i[PRIO_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic above;
    assign above     = no_limit || (prio_i[i*PRIO_W +: PRIO_W] > limit);
    assign qual_o[i] = irq_src_i[i] && en_i[i] && above;
  end

endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        qual_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);

  // Ascending scan: ">=" lets a later (higher-numbered) equal contender win.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);

  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned HALF_W    = DATA_W / 2;
  localparam int unsigned EN_WORDS  = NUM_SRC / DATA_W;
  localparam int unsigned PER_PWORD = DATA_W / PRIO_W;
  localparam int unsigned PR_WORDS  = NUM_SRC / PER_PWORD;

  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [PRIO_W:0]           mask_q;
  logic [NUM_SRC-1:0]        qual;
  logic                      win_valid;
  logic [IDX_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio;
  logic [DATA_W-1:0]         vec_d, vec_q;
  logic                      irq_d, irq_q;

  intc_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .en_o     (en_q),
    .prio_o   (prio_q),
    .thresh_o (mask_q)
  );

  intc_qual #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_qual (
    .irq_src_i (irq_src_i),
    .en_i      (en_q),
    .prio_i    (prio_q),
    .thresh_i  (mask_q),
    .qual_o    (qual)
  );

  intc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .qual_i  (qual),
    .prio_i  (prio_q),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  // Vector word next state
  always_comb begin
    if (win_valid)
      vec_d = {{(HALF_W-IDX_W){1'b0}}, win_idx, {(HALF_W-PRIO_W){1'b0}}, win_prio};
    else
      vec_d = '1;
    irq_d = win_valid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '1;
      irq_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      irq_q <= irq_d;
    end
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_VECTOR))
      rdata_o = vec_q;
    if (addr_i == ADDR_W'(A_THRESH))
      rdata_o = DATA_W'(mask_q);
    for (int w = 0; w < EN_WORDS; w++) begin
      if (addr_i == ADDR_W'(A_SET_BULK + w))
        rdata_o = en_q[w*DATA_W +: DATA_W];
    end
    for (int p = 0; p < PR_WORDS; p++) begin
      if (addr_i == ADDR_W'(A_PRIO_TOP - p))
        rdata_o = prio_q[p*DATA_W +: DATA_W];
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_src_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] en_q,
  input logic [PRIO_W:0]    mask_q,
  input logic [DATA_W-1:0]  vec_q,
  input logic               irq_o
);

  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  // R2
  set_num_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(2) && wdata_i < DATA_W'(NUM_SRC))
    |=> en_q[$past(wdata_i[IDX_W-1:0])]);

  // R3
  clr_num_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(3) && wdata_i < DATA_W'(NUM_SRC))
    |=> !en_q[$past(wdata_i[IDX_W-1:0])]);

  // R7
  vec_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_q[DATA_W-1:DATA_W/2+IDX_W] == '0 && vec_q[DATA_W/2-1:PRIO_W] == '0));

  // R9
  thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q[PRIO_W] |=> (!irq_o || vec_q[PRIO_W-1:0] > $past(mask_q[PRIO_W-1:0])));

  // R10
  idle_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_q != '1));

  // R11
  level_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_src_i & en_q) == '0) |=> !irq_o);

endmodule

bind prio_vec_intc intc_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_src_i (irq_src_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .en_q      (en_q),
  .mask_q    (mask_q),
  .vec_q     (vec_q),
  .irq_o     (irq_o)
);

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;

  logic        clk;
  logic        rst_n;
  logic [63:0] src;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  prio_vec_intc u_prio_vec_intc (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    src = '0; wr_en = 0; addr = '0; wdata = '0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
    addr = 8'h00;
  endtask

  // one further edge so the vector register picks up a register change
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h00, d); check("R1 vector", d, 32'hFFFF_FFFF);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h01, d); check("R1 thresh", d, 32'h1F);
    rd(8'h04, d); check("R1 en lo", d, 32'h0);
    rd(8'h05, d); check("R1 en hi", d, 32'h0);
    rd(8'h18, d); check("R1 prio", d, 32'h0);
  endtask

  task automatic t_num_enable();
    logic [31:0] d;
    do_reset();
    wr(8'h02, 32'd37);
    wr(8'h02, 32'd36);
    rd(8'h05, d); check("R2 set by number", d, 32'h0000_0030);
    wr(8'h02, 32'd70);
    rd(8'h05, d); check("R2 out of range", d, 32'h0000_0030);
    rd(8'h04, d); check("R2 other half", d, 32'h0);
    wr(8'h03, 32'd37);
    rd(8'h05, d); check("R3 clear by number", d, 32'h0000_0010);
  endtask

  task automatic t_bulk();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0000_00F0);
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, d); check("R4 bulk set lo", d, 32'h0000_00F1);
    wr(8'h05, 32'h8000_0000);
    rd(8'h05, d); check("R4 bulk set hi", d, 32'h8000_0000);
    wr(8'h06, 32'h0000_0030);
    rd(8'h04, d); check("R5 bulk clear lo", d, 32'h0000_00C1);
    wr(8'h07, 32'h0000_0001);
    rd(8'h05, d); check("R5 bulk clear hi untouched", d, 32'h8000_0000);
  endtask

  task automatic t_prio_layout();
    logic [31:0] d;
    do_reset();
    wr(8'h1E, 32'h0090_0000);        // source 13 -> 9
    rd(8'h1E, d); check("R6 readback", d, 32'h0090_0000);
    wr(8'h02, 32'd13);
    src[13] = 1'b1;
    settle();
    rd(8'h00, d); check("R6 source 13 vector", d, 32'h000D_0009);
    wr(8'h18, 32'hB000_0000);        // source 63 -> 11
    wr(8'h02, 32'd63);
    src[63] = 1'b1;
    settle();
    rd(8'h00, d); check("R6 source 63 vector", d, 32'h003F_000B);
  endtask

  task automatic t_winner();
    logic [31:0] d;
    do_reset();
    wr(8'h1F, 32'h0030_0000);        // source 5 -> 3
    wr(8'h1A, 32'h0000_0007);        // source 40 -> 7
    wr(8'h19, 32'h0000_0200);        // source 50 -> 2
    wr(8'h05, 32'h0004_0100);        // enable 40, 50
    wr(8'h02, 32'd5);
    src[5] = 1; src[40] = 1; src[50] = 1;
    settle();
    rd(8'h00, d); check("R7 highest priority", d, 32'h0028_0007);
    check("R10 irq high", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_tie();
    logic [31:0] d;
    do_reset();
    wr(8'h02, 32'd0);
    wr(8'h02, 32'd63);
    src[0] = 1; src[63] = 1;
    settle();
    rd(8'h00, d); check("R8 tie at zero", d, 32'h003F_0000);
    wr(8'h1E, 32'h0000_0600);        // source 10 -> 6
    wr(8'h1D, 32'h0000_0006);        // source 16 -> 6
    wr(8'h02, 32'd10);
    wr(8'h02, 32'd16);
    src[10] = 1; src[16] = 1;
    settle();
    rd(8'h00, d); check("R8 tie at six", d, 32'h0010_0006);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(8'h1F, 32'h0030_0000);        // source 5 -> 3
    wr(8'h1A, 32'h0000_0007);        // source 40 -> 7
    wr(8'h02, 32'd5);
    wr(8'h02, 32'd40);
    src[5] = 1; src[40] = 1;
    wr(8'h01, 32'h07);
    settle();
    rd(8'h00, d); check("R9 equal to threshold hidden", d, 32'hFFFF_FFFF);
    check("R10 irq low", {31'd0, irq}, 32'd0);
    wr(8'h01, 32'h03);
    settle();
    rd(8'h00, d); check("R9 above threshold", d, 32'h0028_0007);
    wr(8'h03, 32'd40);
    settle();
    rd(8'h00, d); check("R9 source 5 at threshold", d, 32'hFFFF_FFFF);
    wr(8'h01, 32'h02);
    settle();
    rd(8'h00, d); check("R9 source 5 above", d, 32'h0005_0003);
    rd(8'h01, d); check("R9 readback", d, 32'h02);
    wr(8'h01, 32'h1F);
    wr(8'h02, 32'd40);
    settle();
    rd(8'h00, d); check("R9 restored", d, 32'h0028_0007);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    do_reset();
    wr(8'h1F, 32'h1000_0000);        // source 7 -> 1
    wr(8'h02, 32'd7);
    settle();
    @(negedge clk);
    src[7] = 1;
    #0.5;
    check("R11 not before edge", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R11 one edge later", {31'd0, irq}, 32'd1);
    rd(8'h00, d); check("R11 vector", d, 32'h0007_0001);
    src[7] = 0;
    @(negedge clk);
    check("R11 level drop", {31'd0, irq}, 32'd0);
    rd(8'h00, d); check("R10 empty vector", d, 32'hFFFF_FFFF);
    src[20] = 1;                     // pending but disabled
    @(negedge clk);
    check("R10 disabled source", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    rst_n = 0; src = '0; wr_en = 0; addr = '0; wdata = '0;
    t_reset();
    t_num_enable();
    t_bulk();
    t_prio_layout();
    t_winner();
    t_tie();
    t_mask();
    t_timing();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule